// File: doc/BRIEF.md
# Tagged PIO memory load port

This block lets a host fill a local instruction memory and a local data memory one 32-bit word at a time through a small register window. Several independent access ports share the two memories. Each port has its own pair of offset pointers, control flags and a page tag register. A host first programs a port's control register with a starting byte offset and the stepping flags. It then streams words through the port's data register, and the offset moves forward by one word after each access when stepping is enabled.

The instruction memory is divided into 256-byte pages. Each page carries a virtual tag and a secure attribute in a small attribute store, which an execution core reads through a lookup port. Writing a port's tag register arms that port. The next instruction data write from that port records the armed tag and the port's secure flag against the page that holds the write. The data memory side has an offset, stepping flags and a data register only. It has no tag and no secure attribute.

Register accesses take effect on the clock edge that samples the request. Read data comes back one cycle later, qualified by a valid strobe. The asynchronous active-low reset is released to the logic through a two-stage synchroniser.

Top module: `pio_load_port`

## Requirements
- R1: After reset, every port's control registers read 0, every tag register reads 0, and every page attribute reads tag 0 and not secure.
- R2: With step-on-write set, an instruction data write (register code 2) stores the word at the current offset, and the port's offset then reads 4 bytes higher.
- R3: With step-on-write clear, data writes store at the current offset and leave the offset unchanged, so the last word written is the one that remains.
- R4: A data read returns the word at the current offset with `host_rvalid` high on the following cycle. The offset advances by 4 only if step-on-read is set; otherwise it does not move.
- R5: Stepping past the last word of a memory wraps the offset to 0 and sets that side's sticky overflow flag (control bit 31). The flag stays set until the next control write on that side.
- R6: A tag write (register code 1) arms the port. The first instruction data write after that stores the tag and the port's secure flag into the page holding the written offset (byte offset / 256). Later data writes do not alter any page attribute until the port is re-armed.
- R7: The data memory control register (code 3) has no secure flag: bit 18 reads 0 even after being written 1. Data memory writes (code 4) never change page attributes or instruction memory.
- R8: A port's offsets, flags and tag change only on requests addressed to that port.
- R9: Control layout for codes 0 and 3: bits 15:0 hold the byte offset, with bits 1:0 and bits above the memory size ignored. Bit 16 enables step-on-write, bit 17 enables step-on-read, bit 18 is the secure flag (instruction side only), and bit 31 is the read-only overflow flag, which a control write clears.
- R10: Register codes 5 to 7 are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Register access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_port | input | PSW | Access port index |
| host_reg | input | 3 | Register code (0 instr ctl, 1 tag, 2 instr data, 3 data ctl, 4 data data) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |
| attr_page | input | PGW | Page index for attribute lookup |
| attr_tag | output | TAGW | Virtual tag of the looked-up page |
| attr_secure | output | 1 | Secure attribute of the looked-up page |

## Verification
The bench builds the block with its defaults: four ports, a 512-word instruction memory split into eight pages, and a 256-word data memory. At this size every word of both memories can be written and read back in a single run. Every page attribute can be set and checked, and each side's offset can be driven through its full range to wrap. With four ports, one port can be left idle while the others run sweeps, which shows that the ports stay isolated from each other. It also lets the arm-once tag behaviour be checked across a page boundary.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [2:0] {
    REG_ICTL  = 3'd0,
    REG_ITAG  = 3'd1,
    REG_IDATA = 3'd2,
    REG_DCTL  = 3'd3,
    REG_DDATA = 3'd4
  } pio_reg_e;

  localparam int CTL_AW_BIT  = 16;
  localparam int CTL_AR_BIT  = 17;
  localparam int CTL_SEC_BIT = 18;
  localparam int CTL_OVF_BIT = 31;
  localparam int PAGE_BYTES  = 256;
  localparam int PAGE_WORDS  = PAGE_BYTES / 4;
  localparam int PAGE_SHIFT  = $clog2(PAGE_WORDS);
endpackage

// File: rtl/pio_word_mem.sv
module pio_word_mem #(
  parameter int WORDS = 256,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/pio_attr_store.sv
module pio_attr_store #(
  parameter int NPAGE = 8,
  parameter int PGW   = $clog2(NPAGE),
  parameter int TAGW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [PGW-1:0]  wpage,
  input  logic [TAGW-1:0] wtag,
  input  logic            wsec,
  input  logic [PGW-1:0]  rpage,
  output logic [TAGW-1:0] rtag,
  output logic            rsec
);
  logic [TAGW-1:0] tag_q [NPAGE];
  logic            sec_q [NPAGE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAGE; i++) begin
        tag_q[i] <= '0;
        sec_q[i] <= 1'b0;
      end
    end else if (we) begin
      tag_q[wpage] <= wtag;
      sec_q[wpage] <= wsec;
    end
  end

  assign rtag = tag_q[rpage];
  assign rsec = sec_q[rpage];

  // R6: without a write, a page's attribute never moves
  p_attr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (rtag == $past(rtag) && rsec == $past(rsec)) || (rpage != $past(rpage)));
endmodule

// File: rtl/pio_port_regs.sv
module pio_port_regs
  import pio_pkg::*;
#(
  parameter int IAW  = 9,
  parameter int DAW  = 8,
  parameter int TAGW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            wr,
  input  logic            rd,
  input  logic [2:0]      reg_sel,
  input  logic [31:0]     wdata,
  output logic [IAW-1:0]  i_off,
  output logic            i_aw,
  output logic            i_ar,
  output logic            i_sec,
  output logic            i_ovf,
  output logic [DAW-1:0]  d_off,
  output logic            d_aw,
  output logic            d_ar,
  output logic            d_ovf,
  output logic [TAGW-1:0] tag,
  output logic            armed
);
  logic [IAW-1:0]  i_off_n;
  logic            i_aw_n, i_ar_n, i_sec_n, i_ovf_n;
  logic [DAW-1:0]  d_off_n;
  logic            d_aw_n, d_ar_n, d_ovf_n;
  logic [TAGW-1:0] tag_n;
  logic            armed_n;
  logic            i_step, d_step;

  always_comb begin
    i_off_n = i_off;  i_aw_n = i_aw;  i_ar_n = i_ar;  i_sec_n = i_sec;  i_ovf_n = i_ovf;
    d_off_n = d_off;  d_aw_n = d_aw;  d_ar_n = d_ar;  d_ovf_n = d_ovf;
    tag_n   = tag;    armed_n = armed;
    i_step  = (reg_sel == REG_IDATA) && ((wr && i_aw) || (rd && i_ar));
    d_step  = (reg_sel == REG_DDATA) && ((wr && d_aw) || (rd && d_ar));

    if (wr && reg_sel == REG_ICTL) begin
      i_off_n = wdata[IAW+1:2];
      i_aw_n  = wdata[CTL_AW_BIT];
      i_ar_n  = wdata[CTL_AR_BIT];
      i_sec_n = wdata[CTL_SEC_BIT];
      i_ovf_n = 1'b0;
    end else if (i_step) begin
      i_off_n = i_off + 1'b1;
      if (&i_off) i_ovf_n = 1'b1;
    end

    if (wr && reg_sel == REG_DCTL) begin
      d_off_n = wdata[DAW+1:2];
      d_aw_n  = wdata[CTL_AW_BIT];
      d_ar_n  = wdata[CTL_AR_BIT];
      d_ovf_n = 1'b0;
    end else if (d_step) begin
      d_off_n = d_off + 1'b1;
      if (&d_off) d_ovf_n = 1'b1;
    end

    if (wr && reg_sel == REG_ITAG) begin
      tag_n   = wdata[TAGW-1:0];
      armed_n = 1'b1;
    end else if (wr && reg_sel == REG_IDATA) begin
      armed_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_off <= '0;  i_aw <= 1'b0;  i_ar <= 1'b0;  i_sec <= 1'b0;  i_ovf <= 1'b0;
      d_off <= '0;  d_aw <= 1'b0;  d_ar <= 1'b0;  d_ovf <= 1'b0;
      tag   <= '0;  armed <= 1'b0;
    end else if (sel) begin
      i_off <= i_off_n;  i_aw <= i_aw_n;  i_ar <= i_ar_n;  i_sec <= i_sec_n;  i_ovf <= i_ovf_n;
      d_off <= d_off_n;  d_aw <= d_aw_n;  d_ar <= d_ar_n;  d_ovf <= d_ovf_n;
      tag   <= tag_n;    armed <= armed_n;
    end
  end

  // R2: a stepping write moves the instruction offset one word on
  p_wadv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel && wr && reg_sel == REG_IDATA && i_aw |=> i_off == $past(i_off) + 1'b1);
  // R3: a non-stepping write keeps the offset
  p_whold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel && wr && reg_sel == REG_IDATA && !i_aw |=> $stable(i_off));
  // R5: overflow is sticky until a control write
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    i_ovf && !(sel && wr && reg_sel == REG_ICTL) |=> i_ovf);
  // R8: an unaddressed port holds all its state
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(i_off) && $stable(d_off) && $stable(tag) && $stable(armed));
  // R6: a data write consumes the arm
  p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel && wr && reg_sel == REG_IDATA |=> !armed);
endmodule

// File: rtl/pio_load_port.sv
module pio_load_port
  import pio_pkg::*;
#(
  parameter int NPORTS     = 4,
  parameter int IMEM_WORDS = 512,
  parameter int DMEM_WORDS = 256,
  parameter int TAGW       = 16,
  localparam int IAW   = $clog2(IMEM_WORDS),
  localparam int DAW   = $clog2(DMEM_WORDS),
  localparam int NPAGE = IMEM_WORDS / PAGE_WORDS,
  localparam int PGW   = (NPAGE > 1) ? $clog2(NPAGE) : 1,
  localparam int PSW   = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_valid,
  input  logic            host_write,
  input  logic [PSW-1:0]  host_port,
  input  logic [2:0]      host_reg,
  input  logic [31:0]     host_wdata,
  output logic [31:0]     host_rdata,
  output logic            host_rvalid,
  input  logic [PGW-1:0]  attr_page,
  output logic [TAGW-1:0] attr_tag,
  output logic            attr_secure
);
  // reset synchroniser: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [IAW-1:0]  i_off_a [NPORTS];
  logic [DAW-1:0]  d_off_a [NPORTS];
  logic [TAGW-1:0] tag_a   [NPORTS];
  logic [NPORTS-1:0] i_aw_a, i_ar_a, i_sec_a, i_ovf_a, d_aw_a, d_ar_a, d_ovf_a, armed_a, sel_a;
  logic wr_req, rd_req;

  assign wr_req = host_valid && host_write;
  assign rd_req = host_valid && !host_write;

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    assign sel_a[g] = host_valid && (host_port == PSW'(g));
    pio_port_regs #(.IAW(IAW), .DAW(DAW), .TAGW(TAGW)) u_regs (
      .clk(clk), .rst_n(rst_core_n), .sel(sel_a[g]), .wr(wr_req), .rd(rd_req),
      .reg_sel(host_reg), .wdata(host_wdata),
      .i_off(i_off_a[g]), .i_aw(i_aw_a[g]), .i_ar(i_ar_a[g]), .i_sec(i_sec_a[g]),
      .i_ovf(i_ovf_a[g]), .d_off(d_off_a[g]), .d_aw(d_aw_a[g]), .d_ar(d_ar_a[g]),
      .d_ovf(d_ovf_a[g]), .tag(tag_a[g]), .armed(armed_a[g])
    );
  end

  // selected-port view
  logic [IAW-1:0]  s_i_off;
  logic [DAW-1:0]  s_d_off;
  logic [TAGW-1:0] s_tag;
  logic s_i_aw, s_i_ar, s_i_sec, s_i_ovf, s_d_aw, s_d_ar, s_d_ovf, s_armed, port_ok;

  always_comb begin
    s_i_off = '0; s_d_off = '0; s_tag = '0;
    s_i_aw = 1'b0; s_i_ar = 1'b0; s_i_sec = 1'b0; s_i_ovf = 1'b0;
    s_d_aw = 1'b0; s_d_ar = 1'b0; s_d_ovf = 1'b0; s_armed = 1'b0; port_ok = 1'b0;
    for (int p = 0; p < NPORTS; p++) begin
      if (host_port == PSW'(p)) begin
        s_i_off = i_off_a[p]; s_d_off = d_off_a[p]; s_tag = tag_a[p];
        s_i_aw = i_aw_a[p]; s_i_ar = i_ar_a[p]; s_i_sec = i_sec_a[p]; s_i_ovf = i_ovf_a[p];
        s_d_aw = d_aw_a[p]; s_d_ar = d_ar_a[p]; s_d_ovf = d_ovf_a[p]; s_armed = armed_a[p];
        port_ok = 1'b1;
      end
    end
  end

  logic        imem_we, dmem_we, attr_we;
  logic [31:0] imem_rdata, dmem_rdata;

  assign imem_we = wr_req && port_ok && (host_reg == REG_IDATA);
  assign dmem_we = wr_req && port_ok && (host_reg == REG_DDATA);
  assign attr_we = imem_we && s_armed;

  pio_word_mem #(.WORDS(IMEM_WORDS), .AW(IAW)) u_imem (
    .clk(clk), .we(imem_we), .waddr(s_i_off), .wdata(host_wdata),
    .raddr(s_i_off), .rdata(imem_rdata)
  );

  pio_word_mem #(.WORDS(DMEM_WORDS), .AW(DAW)) u_dmem (
    .clk(clk), .we(dmem_we), .waddr(s_d_off), .wdata(host_wdata),
    .raddr(s_d_off), .rdata(dmem_rdata)
  );

  pio_attr_store #(.NPAGE(NPAGE), .PGW(PGW), .TAGW(TAGW)) u_attr (
    .clk(clk), .rst_n(rst_core_n), .we(attr_we),
    .wpage(PGW'(s_i_off >> PAGE_SHIFT)), .wtag(s_tag), .wsec(s_i_sec),
    .rpage(attr_page), .rtag(attr_tag), .rsec(attr_secure)
  );

  // read-back next state
  logic [31:0] rdata_n;
  always_comb begin
    rdata_n = '0;
    if (port_ok) begin
      unique case (host_reg)
        REG_ICTL: begin
          rdata_n[15:0]        = 16'({s_i_off, 2'b00});
          rdata_n[CTL_AW_BIT]  = s_i_aw;
          rdata_n[CTL_AR_BIT]  = s_i_ar;
          rdata_n[CTL_SEC_BIT] = s_i_sec;
          rdata_n[CTL_OVF_BIT] = s_i_ovf;
        end
        REG_ITAG:  rdata_n = 32'(s_tag);
        REG_IDATA: rdata_n = imem_rdata;
        REG_DCTL: begin
          rdata_n[15:0]        = 16'({s_d_off, 2'b00});
          rdata_n[CTL_AW_BIT]  = s_d_aw;
          rdata_n[CTL_AR_BIT]  = s_d_ar;
          rdata_n[CTL_OVF_BIT] = s_d_ovf;
        end
        REG_DDATA: rdata_n = dmem_rdata;
        default:   rdata_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= rd_req;
      if (rd_req) host_rdata <= rdata_n;
    end
  end

  // R4: every read request is answered exactly one cycle later
  p_rvalid_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_req |=> host_rvalid);
  p_rvalid_only_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    !rd_req |=> !host_rvalid);
  // R7: a data memory write leaves the instruction offsets of every port alone
  p_dmem_iso_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    dmem_we |=> $stable(s_i_off) || !$stable(host_port));
endmodule

// File: tb/tb_pio_load_port.sv
module tb_pio_load_port;
  localparam int NP = 4, IW = 512, DW = 256, TW = 16;
  localparam int PSW = 2, PGW = 3;
  localparam logic [31:0] AW = 32'h1 << 16, AR = 32'h1 << 17, SEC = 32'h1 << 18, OVF = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [PSW-1:0] host_port = '0;
  logic [2:0] host_reg = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic host_rvalid;
  logic [PGW-1:0] attr_page = '0;
  logic [TW-1:0] attr_tag;
  logic attr_secure;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [TW-1:0] exp_tag [8];
  logic exp_sec [8];

  always #2 clk = ~clk;

  pio_load_port dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_port(host_port), .host_reg(host_reg), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .attr_page(attr_page),
    .attr_tag(attr_tag), .attr_secure(attr_secure)
  );

  function automatic logic [31:0] ipat(int a);
    return 32'h1234_0000 ^ (32'(a) * 32'h0101_0007);
  endfunction
  function automatic logic [31:0] dpat(int a);
    return 32'hC0DE_0000 + (32'(a) * 32'h0003_0011);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int p, int r, logic [31:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_port = PSW'(p); host_reg = 3'(r); host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic rd(int p, int r, output logic [31:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_port = PSW'(p); host_reg = 3'(r);
    @(negedge clk);
    host_valid = 1'b0;
    if (host_rvalid !== 1'b1) begin
      fails++; checks++;
      $display("FAIL R4: rvalid got %b expected 1", host_rvalid);
    end
    d = host_rdata;
  endtask

  task automatic chk_attr(string req);
    for (int pg = 0; pg < 8; pg++) begin
      attr_page = PGW'(pg);
      #1;
      chk(req, {15'd0, attr_secure, attr_tag}, {15'd0, exp_sec[pg], exp_tag[pg]});
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int p = 0; p < NP; p++) begin
      rd(p, 0, v); chk("R1 ictl", v, 0);
      rd(p, 1, v); chk("R1 tag", v, 0);
      rd(p, 3, v); chk("R1 dctl", v, 0);
    end
    for (int pg = 0; pg < 8; pg++) begin exp_tag[pg] = '0; exp_sec[pg] = 1'b0; end
    chk_attr("R1 attr");

    // R2 / R6 / R5: fill all of instruction memory from port 0, page by page
    for (int pg = 0; pg < 8; pg++) begin
      wr(0, 0, (32'(pg) * 256) | AW | ((pg % 2 == 1) ? SEC : 32'h0));
      wr(0, 1, 32'h40 + 32'(pg * 3));
      exp_tag[pg] = TW'(32'h40 + 32'(pg * 3));
      exp_sec[pg] = (pg % 2 == 1);
      for (int w = 0; w < 64; w++) wr(0, 2, ipat(pg * 64 + w));
      if (pg == 0) begin rd(0, 0, v); chk("R2 offset step", v, 32'h100 | AW); end
    end
    rd(0, 0, v); chk("R5 wrap on write", v, OVF | AW | SEC);
    chk_attr("R6 page attributes");

    // R4 / R5: read back everything from port 1 with step-on-read
    wr(1, 0, AR);
    for (int a = 0; a < IW; a++) begin rd(1, 2, v); chk("R4 imem read", v, ipat(a)); end
    rd(1, 0, v); chk("R5 wrap on read", v, OVF | AR);

    // R4: without step-on-read the offset stays
    wr(1, 0, 32'h40);
    rd(1, 2, v); chk("R4 read hold data", v, ipat(16));
    rd(1, 2, v); chk("R4 read hold data again", v, ipat(16));
    rd(1, 0, v); chk("R4 read hold offset", v, 32'h40);

    // R3: no step-on-write, last write wins; unarmed port leaves attributes
    wr(2, 0, 32'h80);
    wr(2, 2, 32'hDEAD_0001);
    wr(2, 2, 32'hDEAD_0002);
    rd(2, 0, v); chk("R3 offset hold", v, 32'h80);
    rd(2, 2, v); chk("R3 last word", v, 32'hDEAD_0002);
    chk_attr("R6 unarmed write");

    // R6: arm once, write across page 2 into page 3
    wr(3, 1, 32'h7777);
    wr(3, 0, (2 * 256 + 20) | AW);
    for (int w = 0; w < 70; w++) wr(3, 2, ipat(1000 + w));
    exp_tag[2] = 16'h7777; exp_sec[2] = 1'b0;
    chk_attr("R6 arm once");

    // R9: control write masks low and high offset bits and clears overflow
    wr(0, 0, 32'h0000_FFFF);
    rd(0, 0, v); chk("R9 offset mask", v, 32'h7FC);

    // R7 / R5: data memory sweep on port 2
    wr(2, 3, AW | AR | SEC);
    rd(2, 3, v); chk("R7 no dmem secure", v, AW | AR);
    for (int a = 0; a < DW; a++) wr(2, 4, dpat(a));
    rd(2, 3, v); chk("R5 dmem wrap", v, OVF | AW | AR);
    for (int a = 0; a < DW; a++) begin rd(2, 4, v); chk("R7 dmem read", v, dpat(a)); end
    chk_attr("R7 dmem leaves attributes");
    wr(1, 0, 32'h40);
    rd(1, 2, v); chk("R7 imem untouched", v, ipat(16));

    // R8: port 3 state unchanged by other ports' traffic
    rd(3, 0, v); chk("R8 port isolation", v, 32'h32C | AW);
    rd(3, 3, v); chk("R8 port isolation dctl", v, 0);
    rd(3, 1, v); chk("R8 port tag", v, 32'h7777);

    // R10: unused codes ignored and read 0
    wr(0, 7, 32'hFFFF_FFFF);
    wr(0, 5, 32'hFFFF_FFFF);
    rd(0, 0, v); chk("R10 write ignored", v, 32'h7FC);
    rd(0, 5, v); chk("R10 read zero", v, 0);
    rd(0, 7, v); chk("R10 read zero 7", v, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule